// File: doc/BRIEF.md
# Prefetch Pattern Confidence Tracker

This block keeps feedback counters for every entry of a prefetch pattern table and turns them into a 4-bit usefulness level for each entry. It also turns them into one 4-bit global confidence that covers all entries. Each cycle it may receive one outcome event. The event names a table entry and says whether a prefetch issued from that entry was later used, or was evicted without ever being used. The pattern predictions themselves live elsewhere. This block only judges how trustworthy each entry has been.

Each entry collects outcomes until its window holds a programmable number of them. At that point its usefulness is rewritten as the fraction of used outcomes, scaled to the 0..15 range. When an entry reaches full confidence, every other entry loses half of its usefulness, so patterns that have stopped earning credit fade. The global tracker counts the outcomes of all entries the same way. Logic that has no per-entry feedback can fall back on it.

Top module: `pf_conf_tracker`

## Requirements
- R1: After a synchronous active-low reset, every entry's usefulness and the global confidence read 0, and all outcome counters are empty.
- R2: An accepted event (`ev_valid`=1) with `ev_used`=1 adds one to the used count of entry `ev_idx`; with `ev_used`=0 it adds one to that entry's unused count. No other entry's counts change. Counts saturate at 255.
- R3: A window closes when, after counting the current event, used plus unused of that entry is at least `samp_thresh`. The new usefulness is visible from the clock edge that accepts that event. Before that edge the old value stays.
- R4: On a window close, usefulness becomes floor(used × 15 / (used + unused)), and both counts of that entry restart from 0.
- R5: When a window close produces 15, that entry holds 15 and every other entry's usefulness is halved (shift right by one) at the same edge.
- R6: A threshold of 0 or 1 closes a window on every event. A used outcome then yields 15 and an unused outcome yields 0.
- R7: The global confidence runs its own used and unused counts over the events of all entries. It closes its window with the same threshold rule and the same formula as R3 and R4, and it is never halved.
- R8: `rd_usef` shows, combinationally, the usefulness of entry `rd_idx`. `usef_flat` bits [4i+3:4i] show entry i.
- R9: A cycle with `ev_valid`=0 changes no usefulness, no confidence and no count, whatever `ev_used` and `ev_idx` carry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| samp_thresh | input | 8 | Window size in outcomes |
| ev_valid | input | 1 | An outcome event is present |
| ev_used | input | 1 | 1 = prefetch used, 0 = evicted unused |
| ev_idx | input | 6 | Pattern table entry of the event |
| rd_idx | input | 6 | Entry to read |
| rd_usef | output | 4 | Usefulness of entry `rd_idx` |
| usef_flat | output | 256 | Usefulness of all 64 entries, 4 bits each |
| global_conf | output | 4 | Global confidence |

## Verification
The bench builds the block with its default parameters: 64 entries, 8-bit counts and 4-bit levels. Because the window size is a port, the bench sweeps it across 0, 1, 3, 7 and 20 in the same run. Small windows let the bench reach R5 halving chains and the one-event case of R6 within a few cycles. Larger windows exercise mixed used and unused ratios. Random events are confined to a handful of entries, so windows fill often. The bench also mixes in idle cycles that carry random index and outcome values to exercise R9.

// File: rtl/ptc_pkg.sv
// Package: shared encodings for the pattern confidence tracker.
// Assumes: one outcome event per cycle.
package ptc_pkg;
    // Outcome of a prefetch as reported by the cache.
    typedef enum logic {
        OUT_UNUSED = 1'b0,
        OUT_USED   = 1'b1
    } outcome_e;
endpackage

// File: rtl/ptc_ratio.sv
// Module: ptc_ratio
// Computes floor(num * MAX / den), with MAX = 2**OUT_W - 1.
// Assumes: num <= den. A zero den yields 0.
module ptc_ratio #(
    parameter int NUM_W = 8,
    parameter int DEN_W = 9,
    parameter int OUT_W = 4
) (
    input  logic [NUM_W-1:0] num,
    input  logic [DEN_W-1:0] den,
    output logic [OUT_W-1:0] q
);
    localparam int PROD_W = NUM_W + OUT_W;
    localparam logic [PROD_W-1:0] MAXW = PROD_W'((1 << OUT_W) - 1);

    logic [PROD_W-1:0] prod;
    logic [PROD_W-1:0] q_full;

    // Scale then divide.
    always_comb begin
        prod   = PROD_W'(num) * MAXW;
        q_full = (den == '0) ? '0 : prod / PROD_W'(den);
        q      = q_full[OUT_W-1:0];
    end

    // R4: the quotient always fits the level range.
    always_comb begin
        if (den != '0) begin
            a_ratio_fits_r4: assert (q_full <= MAXW);
        end
    end
endmodule

// File: rtl/ptc_sample.sv
// Module: ptc_sample
// Counts one outcome into a used/unused pair and decides a window close.
// Assumes: the caller applies the results only for an accepted event.
module ptc_sample
    import ptc_pkg::*;
#(
    parameter int CNT_W = 8,
    parameter int USE_W = 4
) (
    input  logic [CNT_W-1:0] cur_used,
    input  logic [CNT_W-1:0] cur_unused,
    input  logic             outcome,
    input  logic [CNT_W-1:0] thresh,
    output logic [CNT_W-1:0] nxt_used,
    output logic [CNT_W-1:0] nxt_unused,
    output logic             close,
    output logic [USE_W-1:0] level
);
    localparam int SUM_W = CNT_W + 1;
    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    logic [CNT_W-1:0] inc_used;
    logic [CNT_W-1:0] inc_unused;
    logic [SUM_W-1:0] total;

    // Saturating increment of the counter that matches the outcome.
    always_comb begin
        inc_used   = cur_used;
        inc_unused = cur_unused;
        if (outcome == OUT_USED) begin
            if (cur_used != CNT_MAX) inc_used = cur_used + 1'b1;
        end else begin
            if (cur_unused != CNT_MAX) inc_unused = cur_unused + 1'b1;
        end
        total = {1'b0, inc_used} + {1'b0, inc_unused};
    end

    // Close the window once the event has been counted.
    always_comb begin
        close      = (total >= {1'b0, thresh});
        nxt_used   = close ? '0 : inc_used;
        nxt_unused = close ? '0 : inc_unused;
    end

    ptc_ratio #(
        .NUM_W(CNT_W),
        .DEN_W(SUM_W),
        .OUT_W(USE_W)
    ) u_ratio (
        .num(inc_used),
        .den(total),
        .q  (level)
    );
endmodule

// File: rtl/ptc_entry.sv
// Module: ptc_entry
// Storage of one table entry: counts and usefulness level.
// Assumes: at most one entry is selected per cycle. Aging is requested
// only on the cycle another entry closes a window at full level.
module ptc_entry #(
    parameter int CNT_W = 8,
    parameter int USE_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sel,
    input  logic [CNT_W-1:0] nxt_used,
    input  logic [CNT_W-1:0] nxt_unused,
    input  logic             close,
    input  logic [USE_W-1:0] new_level,
    input  logic             age,
    output logic [CNT_W-1:0] cnt_used,
    output logic [CNT_W-1:0] cnt_unused,
    output logic [USE_W-1:0] level
);
    // Update counts of the selected entry.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_used   <= '0;
            cnt_unused <= '0;
        end else if (sel) begin
            cnt_used   <= nxt_used;
            cnt_unused <= nxt_unused;
        end
    end

    // Write a new level on close, or halve it on an aging request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            level <= '0;
        end else if (sel && close) begin
            level <= new_level;
        end else if (age) begin
            level <= level >> 1;
        end
    end

    // R5: an aged entry holds half its former level.
    property p_age_halves_r5;
        @(posedge clk) disable iff (!rst_n)
        (age && !(sel && close)) |=> (level == ($past(level) >> 1));
    endproperty
    a_age_halves_r5: assert property (p_age_halves_r5);

    // R4: a window close empties both counts.
    property p_close_clears_r4;
        @(posedge clk) disable iff (!rst_n)
        (sel && close) |=> (cnt_used == '0 && cnt_unused == '0);
    endproperty
    a_close_clears_r4: assert property (p_close_clears_r4);

    // R2: an unselected entry keeps its counts.
    property p_idle_counts_r2;
        @(posedge clk) disable iff (!rst_n)
        !sel |=> ($stable(cnt_used) && $stable(cnt_unused));
    endproperty
    a_idle_counts_r2: assert property (p_idle_counts_r2);
endmodule

// File: rtl/ptc_global.sv
// Module: ptc_global
// Global confidence over the outcomes of all entries.
// Assumes: same threshold as the per-entry windows; never aged.
module ptc_global #(
    parameter int CNT_W = 8,
    parameter int USE_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ev_valid,
    input  logic             outcome,
    input  logic [CNT_W-1:0] thresh,
    output logic [USE_W-1:0] conf
);
    logic [CNT_W-1:0] g_used;
    logic [CNT_W-1:0] g_unused;
    logic [CNT_W-1:0] g_nxt_used;
    logic [CNT_W-1:0] g_nxt_unused;
    logic             g_close;
    logic [USE_W-1:0] g_level;

    ptc_sample #(
        .CNT_W(CNT_W),
        .USE_W(USE_W)
    ) u_sample (
        .cur_used  (g_used),
        .cur_unused(g_unused),
        .outcome   (outcome),
        .thresh    (thresh),
        .nxt_used  (g_nxt_used),
        .nxt_unused(g_nxt_unused),
        .close     (g_close),
        .level     (g_level)
    );

    // Count every accepted outcome and recompute on close.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            g_used   <= '0;
            g_unused <= '0;
            conf     <= '0;
        end else if (ev_valid) begin
            g_used   <= g_nxt_used;
            g_unused <= g_nxt_unused;
            if (g_close) conf <= g_level;
        end
    end

    // R7: confidence moves only on a close.
    property p_global_moves_on_close_r7;
        @(posedge clk) disable iff (!rst_n)
        !(ev_valid && g_close) |=> $stable(conf);
    endproperty
    a_global_moves_on_close_r7: assert property (p_global_moves_on_close_r7);
endmodule

// File: rtl/pf_conf_tracker.sv
// Module: pf_conf_tracker (top)
// Per-entry usefulness and global confidence for a prefetch pattern table.
// Assumes: one outcome event per cycle; a shared counting path serves the
// addressed entry, so an event is always counted before its window closes.
module pf_conf_tracker
    import ptc_pkg::*;
#(
    parameter int N_ENT = 64,
    parameter int CNT_W = 8,
    parameter int USE_W = 4
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [CNT_W-1:0]       samp_thresh,
    input  logic                   ev_valid,
    input  logic                   ev_used,
    input  logic [$clog2(N_ENT)-1:0] ev_idx,
    input  logic [$clog2(N_ENT)-1:0] rd_idx,
    output logic [USE_W-1:0]       rd_usef,
    output logic [N_ENT*USE_W-1:0] usef_flat,
    output logic [USE_W-1:0]       global_conf
);
    localparam int IDX_W = $clog2(N_ENT);
    localparam logic [USE_W-1:0] LVL_MAX = '1;

    logic [CNT_W-1:0] ent_used   [N_ENT];
    logic [CNT_W-1:0] ent_unused [N_ENT];
    logic [USE_W-1:0] ent_level  [N_ENT];

    logic [CNT_W-1:0] sel_used;
    logic [CNT_W-1:0] sel_unused;
    logic [CNT_W-1:0] nxt_used;
    logic [CNT_W-1:0] nxt_unused;
    logic             close;
    logic [USE_W-1:0] new_level;
    logic             age_all;

    // Fetch the counts of the addressed entry.
    always_comb begin
        sel_used   = ent_used[ev_idx];
        sel_unused = ent_unused[ev_idx];
    end

    ptc_sample #(
        .CNT_W(CNT_W),
        .USE_W(USE_W)
    ) u_sample (
        .cur_used  (sel_used),
        .cur_unused(sel_unused),
        .outcome   (ev_used),
        .thresh    (samp_thresh),
        .nxt_used  (nxt_used),
        .nxt_unused(nxt_unused),
        .close     (close),
        .level     (new_level)
    );

    // Request aging when a close reaches full confidence.
    always_comb begin
        age_all = ev_valid && close && (new_level == LVL_MAX);
    end

    for (genvar i = 0; i < N_ENT; i++) begin : g_ent
        logic sel_i;
        assign sel_i = ev_valid && (ev_idx == IDX_W'(i));
        ptc_entry #(
            .CNT_W(CNT_W),
            .USE_W(USE_W)
        ) u_entry (
            .clk       (clk),
            .rst_n     (rst_n),
            .sel       (sel_i),
            .nxt_used  (nxt_used),
            .nxt_unused(nxt_unused),
            .close     (close),
            .new_level (new_level),
            .age       (age_all),
            .cnt_used  (ent_used[i]),
            .cnt_unused(ent_unused[i]),
            .level     (ent_level[i])
        );
        assign usef_flat[i*USE_W +: USE_W] = ent_level[i];
    end

    // Read port.
    always_comb begin
        rd_usef = ent_level[rd_idx];
    end

    ptc_global #(
        .CNT_W(CNT_W),
        .USE_W(USE_W)
    ) u_global (
        .clk     (clk),
        .rst_n   (rst_n),
        .ev_valid(ev_valid),
        .outcome (ev_used),
        .thresh  (samp_thresh),
        .conf    (global_conf)
    );

    // R9: idle cycles leave every level and the confidence untouched.
    property p_idle_no_change_r9;
        @(posedge clk) disable iff (!rst_n)
        !ev_valid |=> ($stable(usef_flat) && $stable(global_conf));
    endproperty
    a_idle_no_change_r9: assert property (p_idle_no_change_r9);

    // R5: the entry closing at full level holds the maximum.
    property p_full_holds_r5;
        @(posedge clk) disable iff (!rst_n)
        age_all |=> (ent_level[$past(ev_idx)] == LVL_MAX);
    endproperty
    a_full_holds_r5: assert property (p_full_holds_r5);

    // R6: a threshold of at most one closes a window on every event.
    property p_unit_window_r6;
        @(posedge clk) disable iff (!rst_n)
        (ev_valid && samp_thresh <= CNT_W'(1)) |-> close;
    endproperty
    a_unit_window_r6: assert property (p_unit_window_r6);
endmodule

// File: tb/pf_conf_tracker_test.sv
`timescale 1ns/1ps
module pf_conf_tracker_test;
    localparam int N = 64;

    logic         clk = 1'b0;
    logic         rst_n;
    logic [7:0]   samp_thresh;
    logic         ev_valid;
    logic         ev_used;
    logic [5:0]   ev_idx;
    logic [5:0]   rd_idx;
    logic [3:0]   rd_usef;
    logic [255:0] usef_flat;
    logic [3:0]   global_conf;

    int checks = 0;
    int errors = 0;

    int m_used [N];
    int m_unused [N];
    int m_lvl [N];
    int g_used, g_unused, g_lvl;

    always #2.5 clk = ~clk;

    pf_conf_tracker uut (
        .clk(clk), .rst_n(rst_n), .samp_thresh(samp_thresh),
        .ev_valid(ev_valid), .ev_used(ev_used), .ev_idx(ev_idx),
        .rd_idx(rd_idx), .rd_usef(rd_usef), .usef_flat(usef_flat),
        .global_conf(global_conf)
    );

    function automatic int ratio(int u, int s);
        return (u * 15) / s;
    endfunction

    // Reference model of one accepted event.
    task automatic model_event(input bit used, input int idx);
        int t;
        t = (samp_thresh == 0) ? 0 : int'(samp_thresh);
        if (used) m_used[idx] = (m_used[idx] < 255) ? m_used[idx] + 1 : 255;
        else      m_unused[idx] = (m_unused[idx] < 255) ? m_unused[idx] + 1 : 255;
        if (m_used[idx] + m_unused[idx] >= t) begin
            int lv;
            lv = ratio(m_used[idx], m_used[idx] + m_unused[idx]);
            if (lv == 15)
                for (int j = 0; j < N; j++) m_lvl[j] = m_lvl[j] >> 1;
            m_lvl[idx] = lv;
            m_used[idx] = 0;
            m_unused[idx] = 0;
        end
        if (used) g_used = (g_used < 255) ? g_used + 1 : 255;
        else      g_unused = (g_unused < 255) ? g_unused + 1 : 255;
        if (g_used + g_unused >= t) begin
            g_lvl = ratio(g_used, g_used + g_unused);
            g_used = 0;
            g_unused = 0;
        end
    endtask

    task automatic check_all(input string req);
        int bad;
        bad = -1;
        for (int j = 0; j < N; j++)
            if (int'(usef_flat[j*4 +: 4]) != m_lvl[j] && bad < 0) bad = j;
        checks++;
        if (bad >= 0) begin
            errors++;
            $display("FAIL %s entry %0d level got %0d expected %0d", req, bad,
                     usef_flat[bad*4 +: 4], m_lvl[bad]);
        end
        checks++;
        if (int'(global_conf) != g_lvl) begin
            errors++;
            $display("FAIL R7 global got %0d expected %0d", global_conf, g_lvl);
        end
    endtask

    task automatic check_read(input int idx);
        rd_idx = 6'(idx);
        #0.2;
        checks++;
        if (int'(rd_usef) != m_lvl[idx]) begin
            errors++;
            $display("FAIL R8 read %0d got %0d expected %0d", idx, rd_usef, m_lvl[idx]);
        end
    endtask

    // Drive one cycle at the falling edge, sample just after the rising edge.
    task automatic cycle(input bit v, input bit used, input int idx, input string req);
        @(negedge clk);
        ev_valid = v;
        ev_used  = used;
        ev_idx   = 6'(idx);
        @(posedge clk);
        #1;
        ev_valid = 1'b0;
        if (v) model_event(used, idx);
        check_all(req);
    endtask

    initial begin
        #(5.0 * 150000);
        errors++;
        $display("FAIL watchdog expired");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'd1234));
        rst_n = 1'b0; samp_thresh = 8'd4; ev_valid = 1'b0; ev_used = 1'b0;
        ev_idx = '0; rd_idx = '0;
        for (int j = 0; j < N; j++) begin m_used[j] = 0; m_unused[j] = 0; m_lvl[j] = 0; end
        g_used = 0; g_unused = 0; g_lvl = 0;
        repeat (4) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        #1;
        check_all("R1");
        check_read(0);

        // R3/R4: window of 4 on entry 3, level must stay until the 4th outcome.
        cycle(1, 1, 3, "R2");
        cycle(1, 1, 3, "R2");
        cycle(1, 0, 3, "R3");
        checks++;
        if (usef_flat[3*4 +: 4] != 4'd0) begin
            errors++;
            $display("FAIL R3 early level got %0d expected 0", usef_flat[3*4 +: 4]);
        end
        cycle(1, 1, 3, "R4");
        checks++;
        if (usef_flat[3*4 +: 4] != 4'd11) begin
            errors++;
            $display("FAIL R4 level got %0d expected 11", usef_flat[3*4 +: 4]);
        end
        check_read(3);

        // R5: entry 5 closes at 15, entry 3 is halved to 5.
        for (int k = 0; k < 4; k++) cycle(1, 1, 5, "R5");
        checks++;
        if (usef_flat[3*4 +: 4] != 4'd5 || usef_flat[5*4 +: 4] != 4'd15) begin
            errors++;
            $display("FAIL R5 e3 got %0d expected 5, e5 got %0d expected 15",
                     usef_flat[3*4 +: 4], usef_flat[5*4 +: 4]);
        end

        // R9: idle cycles with random payload change nothing.
        for (int k = 0; k < 20; k++) cycle(0, 1'($urandom), int'($urandom % N), "R9");

        // R6: threshold 0 and 1 close every event.
        samp_thresh = 8'd1;
        cycle(1, 0, 5, "R6");
        cycle(1, 1, 7, "R6");
        samp_thresh = 8'd0;
        cycle(1, 0, 7, "R6");
        cycle(1, 1, 9, "R6");
        check_read(9);

        // Random phases over a handful of entries.
        foreach (samp_thresh[b]) begin end
        for (int ph = 0; ph < 4; ph++) begin
            case (ph)
                0: samp_thresh = 8'd3;
                1: samp_thresh = 8'd7;
                2: samp_thresh = 8'd20;
                default: samp_thresh = 8'd1;
            endcase
            for (int k = 0; k < 300; k++) begin
                int idx;
                bit used;
                bit v;
                idx  = int'($urandom % 6) * 11;
                used = ($urandom % 4) != 0;
                v    = ($urandom % 8) != 0;
                cycle(v, used, idx, v ? "R2" : "R9");
                if (k % 10 == 0) check_read(int'($urandom % N));
            end
        end

        // R2 saturation path not reachable with thresh<=255; check large window.
        samp_thresh = 8'd255;
        for (int k = 0; k < 260; k++) cycle(1, 1'(k % 3 != 0), 20, "R4");

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule